// File: doc/BRIEF.md
# SD Command Response Checker

This block sits behind the command-line transmitter of an SD host. When a command has gone out, a one-cycle `start` pulse hands over the issued command index, the expected response type and five per-command check enables. The block then watches the serial command line on every SD clock enable. It waits for a start bit and shifts in the response. As the bits arrive it runs a CRC7, and at the last bit it judges the frame.

When the frame ends, or when no response arrives in time, the block raises `done` for one cycle. Its error flags stay valid until the next `start`. The received bits are exposed as a 128-bit word that software views as eight 16-bit halfwords, together with the received 7-bit CRC field. For responses that signal busy, `done` is held back until the card releases the busy level.

Top module: `sd_resp_check`

## Requirements
- R1: With response type 0 (no response), `done` is high in the cycle after `start` is sampled, all error flags are low, and no line activity is awaited.
- R2: If no 0 is sampled on `cmd_in` within TIMEOUT (default 64) clock enables after `start`, `err_timeout` and `done` rise together after the TIMEOUT-th enable and no other flag is set; a start bit on exactly the TIMEOUT-th enable is accepted.
- R3: With `chk_tbit` set, a 1 in the second frame bit (the transmission bit, which must be 0) raises `err_tbit`.
- R4: With `chk_start` set, a start bit sampled on the very first enable after `start` (the line was never seen idle high) raises `err_start`; the frame is still received.
- R5: With `chk_crc` set, a mismatch between the received 7-bit CRC field and the CRC7 computed by x^7 + x^3 + 1 from a zero seed raises `err_crc`. For 48-bit frames the CRC covers the first 40 bits, start bit included. With `chk_crc` clear, `err_crc` never rises.
- R6: With `chk_idx` set and a 48-bit response type (2 or 3), a 6-bit index field at frame bits 45:40 that differs from `cmd_idx` raises `err_index`. The index is never checked for type 1.
- R7: With `chk_end` set, a 0 in the last frame bit raises `err_end`.
- R8: For type 1 (136-bit), the CRC covers only the 120-bit payload at frame bits 127:8. The first eight frame bits (start, transmission bit and six reserved bits) are not part of the CRC.
- R9: For type 3 (48-bit with busy), `done` rises only in the cycle after `ready_in` is seen high once the frame has ended; the error flags are already valid when the frame ends.
- R10: `resp_data` holds frame bits 127:0 with frame bit 0 (the end bit) in `resp_data[0]`. A 48-bit frame occupies bits 47:0 and the upper bits are 0. `resp_crc` equals frame bits 7:1.
- R11: A `start` clears every error flag and `resp_data` in the next cycle. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command issued; latches the per-command settings |
| cmd_idx | input | 6 | Index of the issued command |
| resp_type | input | 2 | 0 none, 1 136-bit, 2 48-bit, 3 48-bit with busy |
| chk_crc | input | 1 | Enable CRC7 check |
| chk_idx | input | 1 | Enable index check |
| chk_start | input | 1 | Enable start bit check |
| chk_end | input | 1 | Enable end bit check |
| chk_tbit | input | 1 | Enable transmission bit check |
| sd_ce | input | 1 | SD clock enable; the line is sampled when high |
| cmd_in | input | 1 | Serial command line |
| ready_in | input | 1 | Busy level of the card; high means released |
| done | output | 1 | Command complete pulse |
| resp_data | output | 128 | Received frame bits 127:0 (eight halfwords) |
| resp_crc | output | 7 | Received CRC field |
| err_timeout | output | 1 | No response in time |
| err_crc | output | 1 | CRC7 mismatch |
| err_index | output | 1 | Returned index differs |
| err_start | output | 1 | Start bit seen too early |
| err_end | output | 1 | End bit was 0 |
| err_tbit | output | 1 | Transmission bit was 1 |

## Verification
The CRC check and the index check are judged on the same clock enable, the one that carries the last frame bit. The bench provokes both at once by flipping an index bit after the CRC has been computed over the clean frame. It sweeps the enable masks so that both flags, only one flag, or neither must appear in the same `done` cycle. The same flip in a 136-bit frame lands in the payload, and there it must produce a CRC error with no index error.

// File: rtl/sd_resp_check.sv
module sd_resp_check #(
  parameter int TIMEOUT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   cmd_idx,
  input  logic [1:0]   resp_type,
  input  logic         chk_crc,
  input  logic         chk_idx,
  input  logic         chk_start,
  input  logic         chk_end,
  input  logic         chk_tbit,
  input  logic         sd_ce,
  input  logic         cmd_in,
  input  logic         ready_in,
  output logic         done,
  output logic [127:0] resp_data,
  output logic [6:0]   resp_crc,
  output logic         err_timeout,
  output logic         err_crc,
  output logic         err_index,
  output logic         err_start,
  output logic         err_end,
  output logic         err_tbit
);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RX, S_BUSY} st_t;

  st_t          st;
  logic [1:0]   typ;
  logic [5:0]   idx_q;
  logic [4:0]   en_q;
  logic [TW-1:0] cnt;
  logic [7:0]   pos;
  logic [6:0]   crc;
  logic [127:0] sr;

  wire         long_r = (typ == 2'd1);
  wire [7:0]   last   = long_r ? 8'd135 : 8'd47;
  wire         in_crc = long_r ? (pos >= 8'd8 && pos <= 8'd127) : (pos <= 8'd39);
  wire         fb     = crc[6] ^ cmd_in;
  wire [6:0]   crc_nx = {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  wire [127:0] sr_nx  = {sr[126:0], cmd_in};

  assign resp_data = sr;
  assign resp_crc  = sr[7:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      typ <= 2'd0;
      idx_q <= 6'd0;
      en_q <= 5'd0;
      cnt <= '0;
      pos <= 8'd0;
      crc <= 7'd0;
      sr <= '0;
      done <= 1'b0;
      err_timeout <= 1'b0;
      err_crc <= 1'b0;
      err_index <= 1'b0;
      err_start <= 1'b0;
      err_end <= 1'b0;
      err_tbit <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        typ <= resp_type;
        idx_q <= cmd_idx;
        en_q <= {chk_tbit, chk_end, chk_start, chk_idx, chk_crc};
        cnt <= '0;
        pos <= 8'd0;
        crc <= 7'd0;
        sr <= '0;
        err_timeout <= 1'b0;
        err_crc <= 1'b0;
        err_index <= 1'b0;
        err_start <= 1'b0;
        err_end <= 1'b0;
        err_tbit <= 1'b0;
        if (resp_type == 2'd0) begin
          st <= S_IDLE;
          done <= 1'b1;
        end else begin
          st <= S_WAIT;
        end
      end else begin
        case (st)
          S_WAIT: if (sd_ce) begin
            if (!cmd_in) begin
              st <= S_RX;
              pos <= 8'd1;
              sr <= sr_nx;
              if (cnt == '0 && en_q[2]) err_start <= 1'b1;
            end else if (cnt == TW'(TIMEOUT - 1)) begin
              err_timeout <= 1'b1;
              done <= 1'b1;
              st <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RX: if (sd_ce) begin
            sr <= sr_nx;
            pos <= pos + 8'd1;
            if (in_crc) crc <= crc_nx;
            if (pos == 8'd1 && cmd_in && en_q[4]) err_tbit <= 1'b1;
            if (pos == last) begin
              if (en_q[3] && !cmd_in) err_end <= 1'b1;
              if (en_q[0] && sr_nx[7:1] != crc) err_crc <= 1'b1;
              if (en_q[1] && !long_r && sr_nx[45:40] != idx_q) err_index <= 1'b1;
              if (typ == 2'd3) begin
                st <= S_BUSY;
              end else begin
                st <= S_IDLE;
                done <= 1'b1;
              end
            end
          end
          S_BUSY: if (ready_in) begin
            done <= 1'b1;
            st <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sd_resp_check_chk.sv
module sd_resp_check_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   resp_type,
  input logic         chk_crc,
  input logic         ready_in,
  input logic         done,
  input logic         err_timeout,
  input logic         err_crc,
  input logic         err_index,
  input logic         err_start,
  input logic         err_end,
  input logic         err_tbit
);
  logic [1:0] typ_q;
  logic       crc_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q <= 2'd0;
      crc_en_q <= 1'b0;
    end else if (start) begin
      typ_q <= resp_type;
      crc_en_q <= chk_crc;
    end
  end

  wire any_err = err_timeout | err_crc | err_index | err_start | err_end | err_tbit;

  AST_NO_RESP_DONE: assert property (@(posedge clk) disable iff (!rst_n) (start && resp_type == 2'd0) |=> (done && !any_err)); // R1
  AST_TIMEOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n) err_timeout |-> !(err_crc | err_index | err_start | err_end | err_tbit)); // R2
  AST_CRC_GATED: assert property (@(posedge clk) disable iff (!rst_n) !crc_en_q |-> !err_crc); // R5
  AST_NO_IDX_LONG: assert property (@(posedge clk) disable iff (!rst_n) (typ_q == 2'd1) |-> !err_index); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (typ_q == 2'd3 && !ready_in && !start) |=> (!done || err_timeout)); // R9
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) start |=> !any_err); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> !done); // R11
endmodule

bind sd_resp_check sd_resp_check_chk u_chk (.*);

// File: tb/sd_resp_check_bench.sv
module sd_resp_check_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, sd_ce = 1'b0, cmd_in = 1'b1, ready_in = 1'b1;
  logic [5:0] cmd_idx = '0;
  logic [1:0] resp_type = '0;
  logic chk_crc = 0, chk_idx = 0, chk_start = 0, chk_end = 0, chk_tbit = 0;
  logic done, err_timeout, err_crc, err_index, err_start, err_end, err_tbit;
  logic [127:0] resp_data;
  logic [6:0] resp_crc;
  int total = 0, bad = 0;

  sd_resp_check u_sd_resp_check (.*);

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(logic [135:0] f, int hi, int lo);
    logic [6:0] c = 7'd0;
    for (int i = hi; i >= lo; i--) begin
      logic b = c[6] ^ f[i];
      c = {c[5:0], 1'b0} ^ (b ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  task automatic send_bit(logic b);
    @(negedge clk); cmd_in = b; sd_ce = 1'b1;
    @(negedge clk); sd_ce = 1'b0; cmd_in = 1'b1;
  endtask

  task automatic kick(logic [1:0] t, logic [5:0] idx, logic [4:0] en);
    @(negedge clk);
    start = 1'b1; resp_type = t; cmd_idx = idx;
    {chk_tbit, chk_end, chk_start, chk_idx, chk_crc} = en;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(int typ, int corr, logic [4:0] en, int k);
    logic [135:0] f = '0;
    logic [5:0] idx = 6'((k * 7 + typ * 13) % 64);
    logic [31:0] arg = 32'h9E3779B9 * (k + 1);
    int len = (typ == 1) ? 136 : 48;
    int gap = (corr == 5) ? 0 : (k % 4) + 1;
    string rq;
    if (typ == 1) begin
      f[135] = 1'b0; f[134] = 1'b0; f[133:128] = 6'h3f;
      f[127:8] = {arg, ~arg, arg ^ 32'h5a5a1234, arg[23:0]};
    end else begin
      f[47] = 1'b0; f[46] = 1'b0; f[45:40] = idx; f[39:8] = arg;
    end
    if (corr == 1) f[len-2] = 1'b1;
    f[7:1] = (typ == 1) ? crc7(f, 127, 8) : crc7(f, 47, 8);
    f[0] = 1'b1;
    if (corr == 2) f[40] = ~f[40];
    if (corr == 3) f[1] = ~f[1];
    if (corr == 4) f[0] = 1'b0;
    ready_in = (typ == 3) ? 1'b0 : 1'b1;
    kick(2'(typ), idx, en);
    for (int i = 0; i < gap; i++) send_bit(1'b1);
    for (int i = len - 1; i >= 0; i--) send_bit(f[i]);
    if (typ == 3) begin
      check($sformatf("R9 held t%0d c%0d", typ, corr), 128'(done), 128'(0));
      repeat (3) @(negedge clk);
      check("R9 held while busy", 128'(done), 128'(0));
      ready_in = 1'b1;
      @(negedge clk);
      check("R9 done after ready", 128'(done), 128'(1));
    end else begin
      check($sformatf("R10 done t%0d c%0d", typ, corr), 128'(done), 128'(1));
    end
    rq = (typ == 1) ? "R8" : "R5";
    check($sformatf("R3 tbit t%0d c%0d e%b", typ, corr, en), 128'(err_tbit), 128'(en[4] && corr == 1));
    check($sformatf("R7 end t%0d c%0d e%b", typ, corr, en), 128'(err_end), 128'(en[3] && corr == 4));
    check($sformatf("R4 start t%0d c%0d e%b", typ, corr, en), 128'(err_start), 128'(en[2] && corr == 5));
    check($sformatf("R6 index t%0d c%0d e%b", typ, corr, en), 128'(err_index), 128'(en[1] && corr == 2 && typ != 1));
    check($sformatf("%s crc t%0d c%0d e%b", rq, typ, corr, en), 128'(err_crc), 128'(en[0] && (corr == 2 || corr == 3)));
    check("R2 no timeout", 128'(err_timeout), 128'(0));
    check($sformatf("R10 data t%0d c%0d", typ, corr), resp_data, (typ == 1) ? f[127:0] : {80'b0, f[47:0]});
    check("R10 crc field", 128'(resp_crc), 128'(f[7:1]));
    @(negedge clk);
    check("R11 done pulse", 128'(done), 128'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] ens [4] = '{5'b00000, 5'b11111, 5'b10101, 5'b01010};
    repeat (3) @(negedge clk);
    check("R11 reset done", 128'(done), 128'(0));
    check("R11 reset flags", 128'({err_timeout, err_crc, err_index, err_start, err_end, err_tbit}), 128'(0));
    check("R10 reset data", resp_data, 128'(0));
    rst_n = 1'b1;

    kick(2'd0, 6'd5, 5'b11111);
    check("R1 done at once", 128'(done), 128'(1));
    check("R1 no flags", 128'({err_timeout, err_crc, err_index, err_start, err_end, err_tbit}), 128'(0));
    @(negedge clk);
    check("R1 pulse ends", 128'(done), 128'(0));

    kick(2'd2, 6'd9, 5'b11111);
    for (int i = 0; i < 63; i++) send_bit(1'b1);
    check("R2 not yet", 128'(done), 128'(0));
    send_bit(1'b1);
    check("R2 timeout done", 128'(done), 128'(1));
    check("R2 timeout flags", 128'({err_timeout, err_crc, err_index, err_start, err_end, err_tbit}), 128'(6'b100000));

    begin
      logic [47:0] g;
      g = {2'b00, 6'd17, 32'hCAFE0123, 8'h00};
      g[7:1] = crc7(136'(g), 47, 8);
      g[0] = 1'b1;
      kick(2'd2, 6'd17, 5'b11111);
      for (int i = 0; i < 63; i++) send_bit(1'b1);
      for (int i = 47; i >= 0; i--) send_bit(g[i]);
      check("R2 start on last enable", 128'(done), 128'(1));
      check("R2 boundary flags", 128'({err_timeout, err_crc, err_index, err_start, err_end, err_tbit}), 128'(0));
    end

    for (int t = 1; t <= 3; t++)
      for (int c = 0; c < 6; c++)
        for (int e = 0; e < 4; e++)
          run(t, c, ens[e], t * 100 + c * 10 + e);

    run(2, 2, 5'b11111, 7);
    kick(2'd2, 6'd3, 5'b11111);
    check("R11 flags cleared", 128'({err_timeout, err_crc, err_index, err_start, err_end, err_tbit}), 128'(0));
    check("R11 data cleared", resp_data, 128'(0));
    kick(2'd0, 6'd0, 5'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule